// File: doc/BRIEF.md
# Processor Interrupt Level Resolver

This block decides, on every clock, which interrupt the processor core should take next. It merges the external interrupt-level lines with the software-interrupt register into one pending-level vector, in which either timer-match flag stands for level 14. It then compares that vector against the core's current priority level and picks the highest eligible level. The result is a registered request line and a 9-bit trap type. A nested external interrupt is held back while the core already services a higher-numbered one at a nonzero trap level.

Beside the level logic sits a one-entry vectored-interrupt receiver. A raise strobe fills it and loads three data words. While it is full, it owns the request and freezes level arbitration completely. A lower strobe empties it and hands control back to the level logic. Trap entry and trap return belong to the core and are not handled here.

Top module: `irq_level_resolver`

## Requirements
- R1: The pending vector is `extLevels` ORed with `softInt[15:0]`, with softint bit 0 (tick match) taken out; softint bits 15:1 each raise the level of the same number.
- R2: When softint bit 0 (tick match) or bit 16 (system-tick match) is set, level 14 is pending.
- R3: When the pending vector is numerically below 2 << `curPil`, the next cycle shows `irqReq`=0 and `trapType`=0.
- R4: Otherwise, with `globalEn` high, the highest pending level above `curPil` wins, and the next cycle shows `irqReq`=1 and `trapType`=0x40 | level.
- R5: When `trapLevel` is nonzero and `curTrapType` has bits 8:4 equal to 0x4 and is numerically above the new trap type, the new interrupt is not raised: `irqReq` and `trapType` keep their values.
- R6: When `globalEn` is low (and no vectored entry is held), the next cycle shows `irqReq`=0 and `trapType`=0.
- R7: `vecRaise` with the receiver empty makes it full, and the next cycle shows `trapType`=0x060, `irqReq`=1, `vecData0`=0x7C0 | `vecNum`, and `vecData1`=`vecData2`=0.
- R8: While the receiver is full, level arbitration has no effect and a further `vecRaise` is ignored: request, trap type and all data words stay unchanged.
- R9: `vecLower` with the receiver full empties it and clears `irqReq` the next cycle; `vecLower` with it empty has no effect.
- R10: `vecRaise` and `vecLower` in the same cycle act on the receiver's current state: raise if empty, lower if full.
- R11: After reset, `irqReq`=0, `trapType`=0, all data words are 0 and the receiver is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| extLevels | input | 16 | External interrupt-level requests, bit n = level n |
| softInt | input | 17 | Software-interrupt register: bit 0 tick match, bits 15:1 levels, bit 16 system-tick match |
| curPil | input | 4 | Current processor interrupt level |
| globalEn | input | 1 | Global interrupt enable |
| trapLevel | input | 3 | Current trap nesting level |
| curTrapType | input | 9 | Trap type of the trap being serviced |
| vecRaise | input | 1 | Vectored interrupt raise strobe |
| vecLower | input | 1 | Vectored interrupt lower strobe |
| vecNum | input | 6 | Interrupt number for a vectored raise |
| irqReq | output | 1 | Registered interrupt request to the core |
| trapType | output | 9 | Trap type of the requested interrupt |
| vecData0 | output | 64 | Vectored data word 0 |
| vecData1 | output | 64 | Vectored data word 1 |
| vecData2 | output | 64 | Vectored data word 2 |

## Verification
Two functions can meet in one cycle: a vectored raise or lower can arrive in the same cycle as a level change that would, by itself, set or clear the request. The bench drives the level inputs with eligible and ineligible patterns while it pulses both strobes, alone and together, with the receiver empty and full. A behavioural model decides each cycle which function takes precedence, and the registered outputs are compared with it one cycle later.

// File: rtl/irq_resolver_pkg.sv
package irq_resolver_pkg;
  localparam int NUM_LVL = 16;
  localparam int LVL_W = $clog2(NUM_LVL);
  localparam int TT_W = 9;
  localparam logic [TT_W-1:0] EXT_BASE_TT = 9'h040;
  localparam logic [TT_W-1:0] VEC_TT = 9'h060;
  localparam logic [4:0] EXT_CLASS = EXT_BASE_TT[8:4];
  localparam logic [4:0] VEC_DATA_TAG = 5'h1F;

  typedef struct packed {
    logic vecLoad;
    logic vecClear;
    logic lvlSet;
    logic lvlClear;
    logic [TT_W-1:0] lvlTt;
  } ctrlStrobe_t;
endpackage

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_resolver_pkg::*;
#(
  parameter int SOFT_W = 17,
  parameter int TICK_BIT = 0,
  parameter int STICK_BIT = 16,
  parameter int TIMER_LVL = 14,
  parameter int TL_W = 3
) (
  input  logic [NUM_LVL-1:0] extLevels,
  input  logic [SOFT_W-1:0]  softInt,
  input  logic [LVL_W-1:0]   curPil,
  input  logic               globalEn,
  input  logic [TL_W-1:0]    trapLevel,
  input  logic [TT_W-1:0]    curTrapType,
  input  logic               vecRaise,
  input  logic               vecLower,
  input  logic               vecBusy,
  output ctrlStrobe_t        strobe
);
  localparam int THR_W = NUM_LVL + 1;

  logic [SOFT_W-1:0]  softMasked;
  logic [NUM_LVL-1:0] pending;
  logic               timerHit;
  logic [THR_W-1:0]   threshold;
  logic               belowThr;
  logic [LVL_W-1:0]   selLvl;
  logic [TT_W-1:0]    newTt;
  logic               nestBlock;
  logic               arbEn;

  always_comb begin
    softMasked = softInt;
    softMasked[TICK_BIT] = 1'b0;
    softMasked[STICK_BIT] = 1'b0;
    timerHit = softInt[TICK_BIT] | softInt[STICK_BIT];
  end

  genvar g;
  generate
    for (g = 0; g < NUM_LVL; g++) begin : g_pend
      if (g == TIMER_LVL) begin : g_tmr
        assign pending[g] = extLevels[g] | softMasked[g] | timerHit;
      end else begin : g_plain
        assign pending[g] = extLevels[g] | softMasked[g];
      end
    end
  endgenerate

  always_comb begin
    threshold = THR_W'(2) << curPil;
    belowThr = {1'b0, pending} < threshold;
  end

  always_comb begin
    selLvl = '0;
    for (int i = 0; i < NUM_LVL; i++) begin
      if (pending[i] && (LVL_W'(i) > curPil)) selLvl = LVL_W'(i);
    end
    newTt = EXT_BASE_TT | TT_W'(selLvl);
  end

  always_comb begin
    nestBlock = (trapLevel != '0) && (curTrapType > newTt) &&
                (curTrapType[8:4] == EXT_CLASS);
    arbEn = ~vecBusy & ~vecRaise;
    strobe.vecLoad = vecRaise & ~vecBusy;
    strobe.vecClear = vecLower & vecBusy;
    strobe.lvlClear = arbEn & (belowThr | ~globalEn);
    strobe.lvlSet = arbEn & ~belowThr & globalEn & ~nestBlock;
    strobe.lvlTt = newTt;
  end
endmodule

// File: rtl/irq_dp.sv
module irq_dp
  import irq_resolver_pkg::*;
#(
  parameter int VNUM_W = 6,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [VNUM_W-1:0] vecNum,
  output logic              irqReq,
  output logic [TT_W-1:0]   trapType,
  output logic              vecBusy,
  output logic [DATA_W-1:0] vecData0,
  output logic [DATA_W-1:0] vecData1,
  output logic [DATA_W-1:0] vecData2
);
  localparam logic [DATA_W-1:0] TAG_WORD = DATA_W'(VEC_DATA_TAG) << 6;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqReq <= 1'b0;
      trapType <= '0;
      vecBusy <= 1'b0;
      vecData0 <= '0;
      vecData1 <= '0;
      vecData2 <= '0;
    end else if (strobe.vecLoad) begin
      vecBusy <= 1'b1;
      trapType <= VEC_TT;
      irqReq <= 1'b1;
      vecData0 <= TAG_WORD | DATA_W'(vecNum);
      vecData1 <= '0;
      vecData2 <= '0;
    end else if (strobe.vecClear) begin
      vecBusy <= 1'b0;
      irqReq <= 1'b0;
    end else if (strobe.lvlClear) begin
      irqReq <= 1'b0;
      trapType <= '0;
    end else if (strobe.lvlSet) begin
      irqReq <= 1'b1;
      trapType <= strobe.lvlTt;
    end
  end
endmodule

// File: rtl/irq_level_resolver.sv
module irq_level_resolver
  import irq_resolver_pkg::*;
#(
  parameter int SOFT_W = 17,
  parameter int TICK_BIT = 0,
  parameter int STICK_BIT = 16,
  parameter int TIMER_LVL = 14,
  parameter int TL_W = 3,
  parameter int VNUM_W = 6,
  parameter int DATA_W = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_LVL-1:0] extLevels,
  input  logic [SOFT_W-1:0]  softInt,
  input  logic [LVL_W-1:0]   curPil,
  input  logic               globalEn,
  input  logic [TL_W-1:0]    trapLevel,
  input  logic [TT_W-1:0]    curTrapType,
  input  logic               vecRaise,
  input  logic               vecLower,
  input  logic [VNUM_W-1:0]  vecNum,
  output logic               irqReq,
  output logic [TT_W-1:0]    trapType,
  output logic [DATA_W-1:0]  vecData0,
  output logic [DATA_W-1:0]  vecData1,
  output logic [DATA_W-1:0]  vecData2
);
  ctrlStrobe_t strobe;
  logic vecBusy;

  irq_ctrl #(
    .SOFT_W(SOFT_W), .TICK_BIT(TICK_BIT), .STICK_BIT(STICK_BIT),
    .TIMER_LVL(TIMER_LVL), .TL_W(TL_W)
  ) u_ctrl (
    .extLevels(extLevels), .softInt(softInt), .curPil(curPil),
    .globalEn(globalEn), .trapLevel(trapLevel), .curTrapType(curTrapType),
    .vecRaise(vecRaise), .vecLower(vecLower), .vecBusy(vecBusy),
    .strobe(strobe)
  );

  irq_dp #(.VNUM_W(VNUM_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .vecNum(vecNum),
    .irqReq(irqReq), .trapType(trapType), .vecBusy(vecBusy),
    .vecData0(vecData0), .vecData1(vecData1), .vecData2(vecData2)
  );
endmodule

// File: rtl/irq_level_resolver_chk.sv
module irq_level_resolver_chk
  import irq_resolver_pkg::*;
#(
  parameter int TL_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic [LVL_W-1:0] curPil,
  input logic             globalEn,
  input logic [TL_W-1:0]  trapLevel,
  input logic             vecRaise,
  input logic             vecLower,
  input logic             vecBusy,
  input logic             irqReq,
  input logic [TT_W-1:0]  trapType
);
  AST_VEC_RAISE: assert property (@(posedge clk) disable iff (!rstN)
    (vecRaise && !vecBusy) |=> (vecBusy && irqReq && trapType == VEC_TT)); // R7

  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (vecBusy && !vecLower) |=> (vecBusy && irqReq && $stable(trapType))); // R8

  AST_VEC_LOWER: assert property (@(posedge clk) disable iff (!rstN)
    (vecLower && vecBusy) |=> (!vecBusy && !irqReq)); // R9

  AST_GLOBAL_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (!vecBusy && !vecRaise && !globalEn) |=> (!irqReq && trapType == '0)); // R6

  AST_ABOVE_PIL: assert property (@(posedge clk) disable iff (!rstN)
    (!vecBusy && !vecRaise && globalEn && trapLevel == '0)
      |=> (!irqReq || trapType[LVL_W-1:0] > $past(curPil))); // R4
endmodule

bind irq_level_resolver irq_level_resolver_chk #(.TL_W(TL_W)) u_chk (
  .clk(clk), .rstN(rstN), .curPil(curPil), .globalEn(globalEn),
  .trapLevel(trapLevel), .vecRaise(vecRaise), .vecLower(vecLower),
  .vecBusy(vecBusy), .irqReq(irqReq), .trapType(trapType)
);

// File: tb/irq_level_resolver_tb.sv
module irq_level_resolver_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] extLevels = '0;
  logic [16:0] softInt = '0;
  logic [3:0]  curPil = '0;
  logic        globalEn = 1'b0;
  logic [2:0]  trapLevel = '0;
  logic [8:0]  curTrapType = '0;
  logic        vecRaise = 1'b0;
  logic        vecLower = 1'b0;
  logic [5:0]  vecNum = '0;
  logic        irqReq;
  logic [8:0]  trapType;
  logic [63:0] vecData0, vecData1, vecData2;

  int checks = 0;
  int errors = 0;
  string phase = "R11";

  // reference model state
  bit mReq, mBusy;
  int mTt;
  longint mD0, mD1, mD2;

  always #2.5 clk = ~clk;

  irq_level_resolver u_dut (
    .clk(clk), .rstN(rstN), .extLevels(extLevels), .softInt(softInt),
    .curPil(curPil), .globalEn(globalEn), .trapLevel(trapLevel),
    .curTrapType(curTrapType), .vecRaise(vecRaise), .vecLower(vecLower),
    .vecNum(vecNum), .irqReq(irqReq), .trapType(trapType),
    .vecData0(vecData0), .vecData1(vecData1), .vecData2(vecData2)
  );

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // behavioural next-state of the requirements, applied at each rising edge
  task automatic modelStep();
    int pend, ntt, thr;
    if (vecRaise && !mBusy) begin
      mBusy = 1; mReq = 1; mTt = 'h60;
      mD0 = 'h7C0 + longint'(vecNum); mD1 = 0; mD2 = 0;
    end else if (vecLower && mBusy) begin
      mBusy = 0; mReq = 0;
    end else if (!mBusy) begin
      pend = int'(extLevels) | (int'(softInt[15:0]) & 'hFFFE);
      if (softInt[0] || softInt[16]) pend = pend | (1 << 14);
      thr = 2 << curPil;
      if (pend < thr || !globalEn) begin
        mReq = 0; mTt = 0;
      end else begin
        for (int lv = 15; lv > int'(curPil); lv--) begin
          if ((pend >> lv) & 1) begin
            ntt = 64 + lv;
            if (!(trapLevel != 0 && int'(curTrapType) > ntt &&
                  (int'(curTrapType) >> 4) == 4)) begin
              mReq = 1; mTt = ntt;
            end
            break;
          end
        end
      end
    end
  endtask

  task automatic compareAll();
    check({phase, " irqReq"}, longint'(irqReq), longint'(mReq));
    check({phase, " trapType"}, longint'(trapType), longint'(mTt));
    check({phase, " vecData0"}, longint'(vecData0), mD0);
    check({phase, " vecData1"}, longint'(vecData1), mD1);
    check({phase, " vecData2"}, longint'(vecData2), mD2);
  endtask

  // one cycle: inputs already set before the rising edge; outputs compared
  // at the following falling edge
  task automatic cycle();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareAll();
  endtask

  task automatic setLvl(logic [15:0] e, logic [16:0] s, logic [3:0] p,
                        logic en, logic [2:0] tl, logic [8:0] ctt);
    extLevels = e; softInt = s; curPil = p; globalEn = en;
    trapLevel = tl; curTrapType = ctt; vecRaise = 0; vecLower = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    mReq = 0; mBusy = 0; mTt = 0; mD0 = 0; mD1 = 0; mD2 = 0;
    repeat (3) @(negedge clk);
    // R11: reset values
    check("R11 irqReq", longint'(irqReq), 0);
    check("R11 trapType", longint'(trapType), 0);
    check("R11 vecData0", longint'(vecData0), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R4: highest above pil wins
    phase = "R4";
    setLvl(16'h0822, 17'h0, 4'd2, 1, 0, 9'h0); cycle();
    check("R4 level 11", longint'(trapType), 'h4B);
    check("R4 req", longint'(irqReq), 1);
    // R3: pending not above pil
    phase = "R3";
    setLvl(16'h0822, 17'h0, 4'd11, 1, 0, 9'h0); cycle();
    check("R3 req cleared", longint'(irqReq), 0);
    check("R3 tt cleared", longint'(trapType), 0);
    // R1: softint levels, tick bit alone not level 0
    phase = "R1";
    setLvl(16'h0, 17'h00008, 4'd0, 1, 0, 9'h0); cycle();
    check("R1 soft level 3", longint'(trapType), 'h43);
    setLvl(16'h0001, 17'h0, 4'd0, 1, 0, 9'h0); cycle();
    check("R1 level 0 never eligible", longint'(irqReq), 0);
    // R2: timer flags fold onto level 14
    phase = "R2";
    setLvl(16'h0, 17'h00001, 4'd5, 1, 0, 9'h0); cycle();
    check("R2 tick -> 14", longint'(trapType), 'h4E);
    setLvl(16'h0, 17'h10000, 4'd13, 1, 0, 9'h0); cycle();
    check("R2 stick -> 14", longint'(trapType), 'h4E);
    setLvl(16'h0, 17'h10000, 4'd14, 1, 0, 9'h0); cycle();
    check("R2 14 not above pil 14", longint'(irqReq), 0);
    // R6: global disable
    phase = "R6";
    setLvl(16'h8000, 17'h0, 4'd0, 1, 0, 9'h0); cycle();
    setLvl(16'h8000, 17'h0, 4'd0, 0, 0, 9'h0); cycle();
    check("R6 req withdrawn", longint'(irqReq), 0);
    check("R6 tt cleared", longint'(trapType), 0);
    // R5: nested suppression
    phase = "R5";
    setLvl(16'h0400, 17'h0, 4'd0, 1, 0, 9'h0); cycle();
    setLvl(16'h2000, 17'h0, 4'd0, 1, 1, 9'h04E); cycle();
    check("R5 lower level held back", longint'(trapType), 'h4A);
    setLvl(16'h8000, 17'h0, 4'd0, 1, 1, 9'h04E); cycle();
    check("R5 higher level passes", longint'(trapType), 'h4F);
    setLvl(16'h2000, 17'h0, 4'd0, 1, 1, 9'h07E); cycle();
    check("R5 other class not blocking", longint'(trapType), 'h4D);
    setLvl(16'h0100, 17'h0, 4'd0, 1, 0, 9'h04E); cycle();
    check("R5 trap level zero passes", longint'(trapType), 'h48);
    // R7: vectored raise
    phase = "R7";
    setLvl(16'h8000, 17'h0, 4'd0, 1, 0, 9'h0);
    vecRaise = 1; vecNum = 6'd5; cycle();
    check("R7 data0", longint'(vecData0), 'h7C5);
    check("R7 tt", longint'(trapType), 'h60);
    // R8: busy blocks arbitration and second raise
    phase = "R8";
    setLvl(16'h0, 17'h0, 4'd15, 0, 0, 9'h0);
    vecRaise = 1; vecNum = 6'd9; cycle();
    check("R8 data0 kept", longint'(vecData0), 'h7C5);
    check("R8 req kept", longint'(irqReq), 1);
    // R10: both strobes while full -> lower
    phase = "R10";
    setLvl(16'h0, 17'h0, 4'd0, 1, 0, 9'h0);
    vecRaise = 1; vecLower = 1; cycle();
    check("R10 lower wins when full", longint'(irqReq), 0);
    // R9: lower when empty no effect; arbitration resumes
    phase = "R9";
    setLvl(16'h0040, 17'h0, 4'd0, 1, 0, 9'h0);
    vecLower = 1; cycle();
    check("R9 arbitration after lower", longint'(trapType), 'h46);
    // R10: both strobes while empty -> raise
    phase = "R10";
    setLvl(16'h0, 17'h0, 4'd0, 1, 0, 9'h0);
    vecRaise = 1; vecLower = 1; vecNum = 6'd63; cycle();
    check("R10 raise wins when empty", longint'(vecData0), 'h7FF);
    setLvl(16'h0, 17'h0, 4'd0, 1, 0, 9'h0); vecLower = 1; cycle();

    // mixed stimulus, vectored strobes colliding with level changes
    phase = "R4/R8 mixed";
    for (int n = 0; n < 2000; n++) begin
      int r;
      r = int'($urandom_range(0, 2));
      extLevels = 16'($urandom) & 16'($urandom);
      softInt = 17'($urandom) & 17'($urandom) & 17'($urandom);
      curPil = 4'($urandom);
      globalEn = ($urandom_range(0, 5) != 0);
      trapLevel = 3'($urandom_range(0, 1));
      curTrapType = (r == 0) ? 9'h030 : (9'h040 | 9'($urandom_range(0, 15)));
      vecRaise = ($urandom_range(0, 12) == 0);
      vecLower = ($urandom_range(0, 10) == 0);
      vecNum = 6'($urandom);
      cycle();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule